// File: doc/BRIEF.md
# Partial-Width General Register File

This block holds sixteen 64-bit general registers and lets a single write port and a single read port work on 8, 16, 32 or 64 bits of a register at a time. The operand size travels with each access, together with an extension flag. The flag changes how the 4-bit register selector is decoded. Without the flag, only three selector bits count, and at byte size four of the eight codes reach the second byte of the first four registers. With the flag, all sixteen registers can be reached at every width, and every byte access is a low byte.

Writes follow fixed width rules. A byte or halfword write merges into the old value and leaves every other bit alone. A word write zero-fills the upper half. A doubleword write replaces the whole register. Reads always return the addressed slice right-aligned and zero-extended. The merge can complete in one cycle, or it can be built as a two-cycle operation. In the two-cycle build, a `busy` output marks the extra cycle and blocks a new write during it.

Top module: `partreg_file`

## Requirements
- R1: After reset every register reads as zero at every width, and `busy` is low.
- R2: With `*_ext` low, selector bit 3 is ignored. At byte size (size code 2'b00), codes 0 to 3 select bits 7:0 of registers 0 to 3, and codes 4 to 7 select bits 15:8 of registers 0 to 3, in that order. At the other sizes, codes 0 to 7 select registers 0 to 7.
- R3: With `*_ext` high, the 4-bit selector names any of registers 0 to 15 at every size. A byte access then always touches bits 7:0, so no second-byte register can be reached.
- R4: A write of size code 2'b10 (32 bits) stores data bits 31:0 in bits 31:0 and clears bits 63:32.
- R5: A write of size code 2'b00 (8 bits) or 2'b01 (16 bits) changes only the addressed bits and keeps all others. A write of size code 2'b11 (64 bits) replaces all 64 bits.
- R6: A read of size code 2'b00, 2'b01 or 2'b10 returns the addressed slice in the low bits with all higher bits zero. A second-byte read returns bits 15:8 of the register in bits 7:0.
- R7: A read and a write to the same register in the same cycle return the old value. The new value can be read from the cycle after the write edge onward.
- R8: With `MERGE_STALL`=1, `busy` is high for exactly the one cycle after an accepted 8-bit or 16-bit write, and a write presented while `busy` is high is ignored. 32-bit and 64-bit writes never raise `busy`. With `MERGE_STALL`=0, `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register selector |
| wr_size | input | 2 | Write size: 00=8, 01=16, 10=32, 11=64 bits |
| wr_ext | input | 1 | Write extension flag |
| wr_data | input | 64 | Write data, right-aligned |
| rd_idx | input | 4 | Read register selector |
| rd_size | input | 2 | Read size, same encoding as `wr_size` |
| rd_ext | input | 1 | Read extension flag |
| rd_data | output | 64 | Zero-extended read slice (combinational) |
| busy | output | 1 | Merge stall cycle in progress; writes ignored |

## Verification
The bench first fills a register with a distinct byte pattern. It then overwrites the low byte, the second byte and the low halfword, so that a wrong merge shows up as a damaged neighbouring byte rather than a plausible value. The same selector codes 4 to 7 are driven with and without the extension flag, which separates second-byte addressing from low-byte addressing of registers 4 to 7. A selector with bit 3 set and the flag low shows whether bit 3 is dropped. Back-to-back writes are applied to the default build and to a stalling build side by side, which separates a merge that completes in one cycle from one whose stall cycle discards the following write.

// File: rtl/partreg_file.sv
module partreg_file #(
  parameter int XLEN = 64,
  parameter int NREGS = 16,
  parameter bit MERGE_STALL = 1'b0,
  localparam int IW = $clog2(NREGS),
  localparam int HALF = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_size,
  input  logic            wr_ext,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IW-1:0]   rd_idx,
  input  logic [1:0]      rd_size,
  input  logic            rd_ext,
  output logic [XLEN-1:0] rd_data,
  output logic            busy
);

  logic [NREGS-1:0][XLEN-1:0] rf;

  // {second-byte flag, register number}
  function automatic logic [IW:0] pick(input logic [IW-1:0] sel,
                                       input logic [1:0] sz,
                                       input logic ext);
    if (ext) return {1'b0, sel};
    if (sz == 2'b00 && sel[2]) return {1'b1, IW'(sel[1:0])};
    return {1'b0, IW'(sel[2:0])};
  endfunction

  logic [IW:0]     wsel, rsel;
  logic            whi, rhi;
  logic [IW-1:0]   wreg, rreg;
  logic [XLEN-1:0] wold, wnew, rraw;
  logic            accept;

  assign wsel = pick(wr_idx, wr_size, wr_ext);
  assign rsel = pick(rd_idx, rd_size, rd_ext);
  assign {whi, wreg} = wsel;
  assign {rhi, rreg} = rsel;
  assign wold = rf[wreg];
  assign rraw = rf[rreg];
  assign accept = wr_en && !busy;

  always_comb begin
    case (wr_size)
      2'b00:   wnew = whi ? {wold[XLEN-1:16], wr_data[7:0], wold[7:0]}
                          : {wold[XLEN-1:8], wr_data[7:0]};
      2'b01:   wnew = {wold[XLEN-1:16], wr_data[15:0]};
      2'b10:   wnew = {{HALF{1'b0}}, wr_data[HALF-1:0]};
      default: wnew = wr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf   <= '0;
      busy <= 1'b0;
    end else begin
      if (accept) rf[wreg] <= wnew;
      busy <= MERGE_STALL && accept && !wr_size[1];
    end
  end

  always_comb begin
    case (rd_size)
      2'b00:   rd_data = XLEN'(rhi ? rraw[15:8] : rraw[7:0]);
      2'b01:   rd_data = XLEN'(rraw[15:0]);
      2'b10:   rd_data = XLEN'(rraw[HALF-1:0]);
      default: rd_data = rraw;
    endcase
  end

endmodule

// File: rtl/partreg_file_chk.sv
module partreg_file_chk #(
  parameter int XLEN = 64,
  parameter int NREGS = 16,
  parameter bit MERGE_STALL = 1'b0,
  localparam int IW = $clog2(NREGS),
  localparam int HALF = XLEN / 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [IW-1:0]              wr_idx,
  input logic [1:0]                 wr_size,
  input logic                       wr_ext,
  input logic [XLEN-1:0]            wr_data,
  input logic [1:0]                 rd_size,
  input logic [XLEN-1:0]            rd_data,
  input logic                       busy,
  input logic [NREGS-1:0][XLEN-1:0] rf
);

  logic [IW-1:0]    tgt;
  logic [XLEN-17:0] tgt_hi;
  logic             take;

  assign tgt = wr_ext ? wr_idx : {1'b0, wr_idx[IW-2:0]};
  assign tgt_hi = rf[tgt][XLEN-1:16];
  assign take = wr_en && !busy;

  p_clear_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_size == 2'b10) |=> (rf[$past(tgt)][XLEN-1:HALF] == '0));

  p_full_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_size == 2'b11) |=> (rf[$past(tgt)] == $past(wr_data)));

  p_keep_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_size == 2'b01) |=> (rf[$past(tgt)][XLEN-1:16] == $past(tgt_hi)));

  p_read_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_size != 2'b11) |-> ((rd_data >> (8 << rd_size)) == '0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (rf == $past(rf)));

  p_stall_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (MERGE_STALL && take && !wr_size[1]) |=> busy);

  p_stall_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (MERGE_STALL && $past(wr_en) && !$past(wr_size[1])));

endmodule

bind partreg_file partreg_file_chk #(
  .XLEN(XLEN), .NREGS(NREGS), .MERGE_STALL(MERGE_STALL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_size(wr_size), .wr_ext(wr_ext), .wr_data(wr_data),
  .rd_size(rd_size), .rd_data(rd_data), .busy(busy), .rf(rf)
);

// File: tb/partreg_file_bench.sv
`timescale 1ns/1ps
module partreg_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_ext = 1'b0, rd_ext = 1'b0;
  logic [3:0]  wr_idx = '0, rd_idx = '0;
  logic [1:0]  wr_size = '0, rd_size = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd0, rd1;
  logic        busy0, busy1;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  partreg_file u_partreg_file (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_ext(wr_ext), .wr_data(wr_data), .rd_idx(rd_idx), .rd_size(rd_size),
    .rd_ext(rd_ext), .rd_data(rd0), .busy(busy0));

  partreg_file #(.MERGE_STALL(1'b1)) u_partreg_file_stall (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_ext(wr_ext), .wr_data(wr_data), .rd_idx(rd_idx), .rd_size(rd_size),
    .rd_ext(rd_ext), .rd_data(rd1), .busy(busy1));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [1:0] sz, input logic ext,
                    input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_ext = ext; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] idx, input logic [1:0] sz, input logic ext,
                    input logic [63:0] exp, input string tag);
    @(negedge clk);
    rd_idx = idx; rd_size = sz; rd_ext = ext;
    #1;
    chk({tag, " single"}, rd0, exp);
    chk({tag, " stall"}, rd1, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) rd(4'(i), 2'b11, 1'b1, 64'h0, "R1 reset value");
    rd(4'd6, 2'b00, 1'b0, 64'h0, "R1 reset byte");
    chk("R1 busy single", 64'(busy0), 64'h0);
    chk("R1 busy stall", 64'(busy1), 64'h0);
  endtask

  task automatic t_widths;
    wr(4'd5, 2'b11, 1'b1, 64'hA5A5_5A5A_0123_4567);
    rd(4'd5, 2'b11, 1'b1, 64'hA5A5_5A5A_0123_4567, "R5 full write");
    wr(4'd5, 2'b10, 1'b1, 64'hFFFF_FFFF_DEAD_BEEF);
    rd(4'd5, 2'b11, 1'b1, 64'h0000_0000_DEAD_BEEF, "R4 upper cleared");
  endtask

  task automatic t_merge;
    wr(4'd2, 2'b11, 1'b1, 64'h1122_3344_5566_7788);
    wr(4'd2, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFAB);
    rd(4'd2, 2'b11, 1'b1, 64'h1122_3344_5566_77AB, "R5 low byte merge");
    wr(4'd6, 2'b00, 1'b0, 64'h0000_0000_0000_00CD);
    rd(4'd2, 2'b11, 1'b1, 64'h1122_3344_5566_CDAB, "R2 second byte write");
    rd(4'd6, 2'b00, 1'b0, 64'h0000_0000_0000_00CD, "R6 second byte read");
    rd(4'd6, 2'b11, 1'b1, 64'h0, "R2 reg6 untouched");
    wr(4'd2, 2'b01, 1'b0, 64'h0000_0000_7777_BEEF);
    rd(4'd2, 2'b11, 1'b1, 64'h1122_3344_5566_BEEF, "R5 halfword merge");
    rd(4'd2, 2'b10, 1'b1, 64'h0000_0000_5566_BEEF, "R6 word read");
    rd(4'd2, 2'b01, 1'b0, 64'h0000_0000_0000_BEEF, "R6 halfword read");
    rd(4'd2, 2'b00, 1'b1, 64'h0000_0000_0000_00EF, "R6 low byte read");
  endtask

  task automatic t_ext;
    wr(4'd6, 2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(4'd6, 2'b00, 1'b1, 64'h0000_0000_0000_005A);
    rd(4'd6, 2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FF5A, "R3 ext byte low of reg6");
    rd(4'd2, 2'b11, 1'b1, 64'h1122_3344_5566_BEEF, "R3 reg2 untouched");
    rd(4'd6, 2'b00, 1'b1, 64'h0000_0000_0000_005A, "R3 ext byte read");
    rd(4'd6, 2'b00, 1'b0, 64'h0000_0000_0000_00BE, "R2 same code no ext");
    wr(4'd13, 2'b01, 1'b1, 64'hAAAA_AAAA_AAAA_1234);
    rd(4'd13, 2'b11, 1'b1, 64'h0000_0000_0000_1234, "R3 upper register");
    wr(4'd10, 2'b11, 1'b0, 64'hCAFE_F00D_0000_0001);
    rd(4'd2, 2'b11, 1'b1, 64'hCAFE_F00D_0000_0001, "R2 bit3 ignored write");
    rd(4'd10, 2'b11, 1'b1, 64'h0, "R2 reg10 untouched");
    rd(4'd10, 2'b11, 1'b0, 64'hCAFE_F00D_0000_0001, "R2 bit3 ignored read");
  endtask

  task automatic t_bypass;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd7; wr_size = 2'b11; wr_ext = 1'b1;
    wr_data = 64'h0BAD_CAFE_1357_9BDF;
    rd_idx = 4'd7; rd_size = 2'b11; rd_ext = 1'b1;
    #1;
    chk("R7 old value same cycle", rd0, 64'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R7 new value next cycle", rd0, 64'h0BAD_CAFE_1357_9BDF);
    @(negedge clk);
  endtask

  task automatic t_stall;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd8; wr_size = 2'b00; wr_ext = 1'b1; wr_data = 64'h11;
    @(negedge clk);
    chk("R8 busy single", 64'(busy0), 64'h0);
    chk("R8 busy stall", 64'(busy1), 64'h1);
    wr_idx = 4'd9; wr_size = 2'b11; wr_data = 64'h99;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 busy one cycle", 64'(busy1), 64'h0);
    rd_idx = 4'd9; rd_size = 2'b11; rd_ext = 1'b1;
    #1;
    chk("R8 write kept single", rd0, 64'h99);
    chk("R8 write dropped stall", rd1, 64'h0);
    rd_idx = 4'd8;
    #1;
    chk("R8 merge landed stall", rd1, 64'h11);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd11; wr_size = 2'b10; wr_data = 64'h5;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 word no busy", 64'(busy1), 64'h0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_widths();
    t_merge();
    t_ext();
    t_bypass();
    t_stall();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule